// File: doc/BRIEF.md
# Strobed Parallel Handshake Port

This block drives one side of a legacy strobed parallel port. On the inside it connects to first-in first-out queues. On the outside it speaks the strobe and buffer-full protocol of a classic peripheral interface chip. One configuration input picks the direction.

In receive direction, the peripheral pulls the request pin low to strobe a word in. The block captures the data bus and asserts the acknowledge pin as an input-buffer-full flag. It pushes the word into the receive queue as soon as that queue has room. After a programmable settling delay it releases the flag.

In transmit direction, the block waits for a word in the transmit queue and then waits the programmable delay. It pops the word, drives it onto the data bus, and one cycle later asserts the acknowledge pin as an output-buffer-full flag. A falling edge on the request pin means the peripheral has taken the word, and the flag then clears.

With both pins left at their default active-low polarity, the port can talk to a peer that uses a long-pulse handshake.

Top module: `ppi_strobe_port`

## Requirements
- R1: While reset is asserted, pin_ack is high (flag inactive), pin_doe, ovr_flag, rx_push and tx_pop are all 0, and pin_dout is 0.
- R2: In receive direction (cfg_out_dir = 0), a falling edge on pin_req captures pin_din. pin_ack goes low on the third rising clock edge after pin_req goes low, and not earlier.
- R3: While the input flag is asserted, the captured word is pushed exactly once (rx_push high for one cycle, rx_data equal to the captured value), in a cycle where rx_full is low. While rx_full stays high, no push happens and pin_ack stays low.
- R4: The input flag deasserts (pin_ack high) on the (cfg_delay+1)th rising edge after the edge that completes the push.
- R5: In receive direction, a falling edge on pin_req while the input flag is asserted is ignored: no capture and no push. It sets ovr_flag, which stays set until reset. This holds even when that falling edge is detected in the same cycle as the push.
- R6: In transmit direction (cfg_out_dir = 1), while the output flag is clear and tx_empty is low, the block pops one word (tx_pop high for one cycle) cfg_delay+1 edges after it first sees data. It drives that word on pin_dout on the same edge, and asserts pin_ack low one edge later.
- R7: In transmit direction, a falling edge on pin_req clears the output flag (pin_ack high) on the third rising edge after pin_req goes low. If the queue holds more data, the next word is then loaded.
- R8: pin_doe is high in transmit direction and low in receive direction. pin_dout stays stable while the output flag is asserted.
- R9: In transmit direction, a falling edge on pin_req while the output flag is clear changes nothing: pin_ack stays high, pin_dout keeps its value and ovr_flag is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_out_dir | input | 1 | 0 = receive direction, 1 = transmit direction |
| cfg_delay | input | DLY_W | Settling delay in clock cycles |
| pin_req | input | 1 | Peripheral strobe (receive) or acknowledge (transmit) |
| pin_din | input | DW | Data bus from the peripheral |
| pin_ack | output | 1 | Input-buffer-full or output-buffer-full flag |
| pin_dout | output | DW | Data bus to the peripheral |
| pin_doe | output | 1 | Output enable for the data bus |
| rx_push | output | 1 | Push strobe into the receive queue |
| rx_data | output | DW | Word pushed into the receive queue |
| rx_full | input | 1 | Receive queue has no room |
| tx_pop | output | 1 | Pop strobe from the transmit queue |
| tx_data | input | DW | Head word of the transmit queue |
| tx_empty | input | 1 | Transmit queue holds no data |
| ovr_flag | output | 1 | Sticky overrun indication |

## Verification
The collision of interest is in receive direction. A second strobe edge can be detected in exactly the cycle in which the held word is pushed and the state leaves its full condition. The bench provokes this as follows: it holds rx_full high after a first capture, drives a second strobe low, and releases rx_full two cycles later, so that the push and the detected edge meet at the same clock edge. The scoreboard then has to see only the first word pushed, ovr_flag set, and the flag released one edge after the push.

// File: rtl/ppi_hs_pkg.sv
package ppi_hs_pkg;

   typedef enum logic [1:0] {
      RX_IDLE = 2'd0,
      RX_FULL = 2'd1,
      RX_HOLD = 2'd2
   } rx_state_e;

   typedef enum logic [1:0] {
      TX_IDLE = 2'd0,
      TX_WAIT = 2'd1,
      TX_LOAD = 2'd2,
      TX_FULL = 2'd3
   } tx_state_e;

endpackage

// File: rtl/ppi_sync.sv
module ppi_sync #(
   parameter int          W       = 1,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   localparam int TOTAL = W * STAGES;

   generate
      if (STAGES == 1) begin : g_single
         logic [W-1:0] r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= RST_VAL;
            else        r <= d;
         end
         assign q = r;
      end else begin : g_chain
         logic [TOTAL-1:0] sh;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh <= {STAGES{RST_VAL}};
            else        sh <= {sh[TOTAL-W-1:0], d};
         end
         assign q = sh[TOTAL-1 -: W];
      end
   endgenerate

endmodule

// File: rtl/ppi_delay.sv
module ppi_delay #(
   parameter int DLY_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [DLY_W-1:0] val,
   output logic             done
);

   logic [DLY_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (load)           cnt <= val;
      else if (cnt != '0)      cnt <= cnt - 1'b1;
   end

   assign done = (cnt == '0);

endmodule

// File: rtl/ppi_rx_ctl.sv
module ppi_rx_ctl
   import ppi_hs_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          abort,
   input  logic          edge_hit,
   input  logic [DW-1:0] din_s,
   input  logic          rx_full,
   input  logic          dly_done,
   output logic          dly_load,
   output logic          rx_push,
   output logic [DW-1:0] rx_data,
   output logic          ibf,
   output logic          ovr
);

   rx_state_e     st;
   logic [DW-1:0] held;

   assign rx_push  = (st == RX_FULL) && !rx_full && !abort;
   assign dly_load = rx_push;
   assign rx_data  = held;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= RX_IDLE;
         held <= '0;
         ibf  <= 1'b0;
         ovr  <= 1'b0;
      end else if (abort) begin
         st  <= RX_IDLE;
         ibf <= 1'b0;
      end else begin
         if (edge_hit && st != RX_IDLE) ovr <= 1'b1;
         case (st)
            RX_IDLE: if (edge_hit) begin
               held <= din_s;
               ibf  <= 1'b1;
               st   <= RX_FULL;
            end
            RX_FULL: if (!rx_full) st <= RX_HOLD;
            RX_HOLD: if (dly_done) begin
               ibf <= 1'b0;
               st  <= RX_IDLE;
            end
            default: st <= RX_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/ppi_tx_ctl.sv
module ppi_tx_ctl
   import ppi_hs_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          abort,
   input  logic          edge_hit,
   input  logic          tx_empty,
   input  logic [DW-1:0] tx_data,
   input  logic          dly_done,
   output logic          dly_load,
   output logic          tx_pop,
   output logic [DW-1:0] dout,
   output logic          obf
);

   tx_state_e st;

   assign dly_load = (st == TX_IDLE) && !tx_empty && !abort;
   assign tx_pop   = (st == TX_WAIT) && dly_done && !abort;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= TX_IDLE;
         dout <= '0;
         obf  <= 1'b0;
      end else if (abort) begin
         st  <= TX_IDLE;
         obf <= 1'b0;
      end else begin
         case (st)
            TX_IDLE: if (!tx_empty) st <= TX_WAIT;
            TX_WAIT: if (dly_done) begin
               dout <= tx_data;
               st   <= TX_LOAD;
            end
            TX_LOAD: begin
               obf <= 1'b1;
               st  <= TX_FULL;
            end
            TX_FULL: if (edge_hit) begin
               obf <= 1'b0;
               st  <= TX_IDLE;
            end
            default: st <= TX_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/ppi_strobe_port.sv
module ppi_strobe_port #(
   parameter int DW          = 8,
   parameter int DLY_W       = 4,
   parameter int SYNC_STAGES = 2,
   parameter bit REQ_ACT_LOW = 1'b1,
   parameter bit ACK_ACT_LOW = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_out_dir,
   input  logic [DLY_W-1:0] cfg_delay,
   input  logic             pin_req,
   input  logic [DW-1:0]    pin_din,
   output logic             pin_ack,
   output logic [DW-1:0]    pin_dout,
   output logic             pin_doe,
   output logic             rx_push,
   output logic [DW-1:0]    rx_data,
   input  logic             rx_full,
   output logic             tx_pop,
   input  logic [DW-1:0]    tx_data,
   input  logic             tx_empty,
   output logic             ovr_flag
);

   initial begin
      assert (DW >= 1)          else $error("DW must be at least 1");
      assert (DLY_W >= 1)       else $error("DLY_W must be at least 1");
      assert (SYNC_STAGES >= 1) else $error("SYNC_STAGES must be at least 1");
   end

   logic req_asrt_raw, req_asrt_s, req_asrt_d, edge_hit;
   logic [DW-1:0] din_s;
   logic mode_q, mode_chg, abort_rx, abort_tx;
   logic rx_load, tx_load, dly_done;
   logic ibf, obf, flag_on;

   // polarity variants of the request pin
   generate
      if (REQ_ACT_LOW) begin : g_req_low
         assign req_asrt_raw = ~pin_req;
      end else begin : g_req_high
         assign req_asrt_raw = pin_req;
      end
   endgenerate

   ppi_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_req_sync (
      .clk(clk), .rst_n(rst_n), .d(req_asrt_raw), .q(req_asrt_s));

   ppi_sync #(.W(DW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_din_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_din), .q(din_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_asrt_d <= 1'b0;
         mode_q     <= 1'b0;
      end else begin
         req_asrt_d <= req_asrt_s;
         mode_q     <= cfg_out_dir;
      end
   end

   assign edge_hit = req_asrt_s & ~req_asrt_d;
   assign mode_chg = cfg_out_dir ^ mode_q;
   assign abort_rx = mode_q | mode_chg;
   assign abort_tx = ~mode_q | mode_chg;

   ppi_delay #(.DLY_W(DLY_W)) u_delay (
      .clk(clk), .rst_n(rst_n), .load(rx_load | tx_load),
      .val(cfg_delay), .done(dly_done));

   ppi_rx_ctl #(.DW(DW)) u_rx (
      .clk(clk), .rst_n(rst_n), .abort(abort_rx), .edge_hit(edge_hit),
      .din_s(din_s), .rx_full(rx_full), .dly_done(dly_done),
      .dly_load(rx_load), .rx_push(rx_push), .rx_data(rx_data),
      .ibf(ibf), .ovr(ovr_flag));

   ppi_tx_ctl #(.DW(DW)) u_tx (
      .clk(clk), .rst_n(rst_n), .abort(abort_tx), .edge_hit(edge_hit),
      .tx_empty(tx_empty), .tx_data(tx_data), .dly_done(dly_done),
      .dly_load(tx_load), .tx_pop(tx_pop), .dout(pin_dout), .obf(obf));

   assign flag_on = ibf | obf;
   assign pin_doe = mode_q;

   generate
      if (ACK_ACT_LOW) begin : g_ack_low
         assign pin_ack = ~flag_on;
      end else begin : g_ack_high
         assign pin_ack = flag_on;
      end
   endgenerate

endmodule

// File: rtl/ppi_port_chk.sv
module ppi_port_chk #(
   parameter int DW          = 8,
   parameter bit ACK_ACT_LOW = 1'b1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          pin_ack,
   input logic          pin_doe,
   input logic [DW-1:0] pin_dout,
   input logic          rx_push,
   input logic          rx_full,
   input logic          tx_pop,
   input logic          tx_empty,
   input logic          ovr_flag
);

   logic ack_on;
   assign ack_on = ACK_ACT_LOW ? ~pin_ack : pin_ack;

   a_r3_push_needs_room: assert property (@(posedge clk) disable iff (!rst_n)
      rx_push |-> (ack_on && !rx_full && !pin_doe));

   a_r3_single_push: assert property (@(posedge clk) disable iff (!rst_n)
      rx_push |=> !rx_push);

   a_r5_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_flag |=> ovr_flag);

   a_r6_pop_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
      tx_pop |-> (!ack_on && !tx_empty && pin_doe));

   a_r6_data_before_flag: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ack_on) && pin_doe) |-> $stable(pin_dout));

   a_r8_dout_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_on && $past(ack_on) && pin_doe) |-> $stable(pin_dout));

endmodule

bind ppi_strobe_port ppi_port_chk #(.DW(DW), .ACK_ACT_LOW(ACK_ACT_LOW)) u_chk (
   .clk(clk), .rst_n(rst_n), .pin_ack(pin_ack), .pin_doe(pin_doe),
   .pin_dout(pin_dout), .rx_push(rx_push), .rx_full(rx_full),
   .tx_pop(tx_pop), .tx_empty(tx_empty), .ovr_flag(ovr_flag));

// File: tb/tb_ppi_strobe_port.sv
`timescale 1ns/1ps
module tb_ppi_strobe_port;
   localparam int DW = 8, DLY_W = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_out_dir = 1'b0;
   logic [DLY_W-1:0] cfg_delay = '0;
   logic pin_req = 1'b1;
   logic [DW-1:0] pin_din = '0;
   logic pin_ack, pin_doe, rx_push, tx_pop, ovr_flag;
   logic [DW-1:0] pin_dout, rx_data;
   logic rx_full = 1'b0;
   logic [DW-1:0] tx_data = '0;
   logic tx_empty = 1'b1;

   int n_cmp = 0, n_bad = 0;
   bit done = 0;
   logic [DW-1:0] rx_exp[$];
   logic [DW-1:0] tx_fifo[$];
   logic [DW-1:0] tx_exp[$];
   bit pop_pend = 0;
   logic ack_prev = 1'b1;

   always #2 clk = ~clk;

   ppi_strobe_port #(.DW(DW), .DLY_W(DLY_W)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_out_dir(cfg_out_dir), .cfg_delay(cfg_delay),
      .pin_req(pin_req), .pin_din(pin_din), .pin_ack(pin_ack), .pin_dout(pin_dout),
      .pin_doe(pin_doe), .rx_push(rx_push), .rx_data(rx_data), .rx_full(rx_full),
      .tx_pop(tx_pop), .tx_data(tx_data), .tx_empty(tx_empty), .ovr_flag(ovr_flag));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1;
      end
   endtask

   function automatic void tx_refresh();
      tx_empty = (tx_fifo.size() == 0);
      tx_data  = (tx_fifo.size() != 0) ? tx_fifo[0] : '0;
   endfunction

   // transmit-queue model: a pop seen in a cycle removes the head after that edge
   always @(negedge clk) begin
      if (pop_pend) begin
         void'(tx_fifo.pop_front());
         pop_pend = 0;
      end
      if (rst_n && tx_pop) pop_pend = 1;
      tx_refresh();
   end

   // receive monitor (R3, R5)
   always @(negedge clk) begin
      if (rst_n && rx_push) begin
         if (rx_exp.size() == 0) chk("R5 unexpected push", {24'd0, rx_data}, 32'hFFFF_FFFF);
         else chk("R3 pushed word", {24'd0, rx_data}, {24'd0, rx_exp.pop_front()});
      end
   end

   // transmit monitor (R6, R7)
   always @(negedge clk) begin
      if (rst_n && pin_doe && ack_prev && !pin_ack) begin
         if (tx_exp.size() == 0) chk("R6 unexpected word", {24'd0, pin_dout}, 32'hFFFF_FFFF);
         else chk("R6 driven word", {24'd0, pin_dout}, {24'd0, tx_exp.pop_front()});
      end
      ack_prev = pin_ack;
   end

   task automatic strobe(input logic [DW-1:0] v, input bit expect_push);
      pin_din = v;
      cyc(1);
      pin_req = 1'b0;
      if (expect_push) rx_exp.push_back(v);
      cyc(3);
      pin_req = 1'b1;
      cyc(2);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      cyc(2);
      rst_n = 1'b1;
      cyc(2);
   endtask

   task automatic tx_word(input logic [DW-1:0] v);
      tx_fifo.push_back(v);
      tx_exp.push_back(v);
      tx_refresh();
   endtask

   initial begin
      cyc(3);
      chk("R1 ack idle", pin_ack, 1);
      chk("R1 doe", pin_doe, 0);
      chk("R1 ovr", ovr_flag, 0);
      chk("R1 push", rx_push, 0);
      chk("R1 pop", tx_pop, 0);
      chk("R1 dout", pin_dout, 0);
      rst_n = 1'b1;
      cyc(2);
      chk("R8 doe receive", pin_doe, 0);

      // R2 / R4: exact timing with delay 3
      cfg_delay = 4'd3;
      pin_din = 8'hA5;
      cyc(1);
      pin_req = 1'b0;
      rx_exp.push_back(8'hA5);
      cyc(2);
      chk("R2 flag not early", pin_ack, 1);
      cyc(1);
      chk("R2 flag asserted", pin_ack, 0);
      pin_req = 1'b1;
      cyc(4);
      chk("R4 flag still held", pin_ack, 0);
      cyc(1);
      chk("R4 flag released", pin_ack, 1);
      chk("R3 queue drained", rx_exp.size(), 0);

      // R3 / R5: queue full, then overrun
      cfg_delay = 4'd0;
      rx_full = 1'b1;
      strobe(8'h3C, 1);
      chk("R3 flag held while full", pin_ack, 0);
      cyc(8);
      chk("R3 flag still held", pin_ack, 0);
      chk("R5 no overrun yet", ovr_flag, 0);
      strobe(8'hC3, 0);
      chk("R5 overrun set", ovr_flag, 1);
      chk("R5 flag unchanged", pin_ack, 0);
      rx_full = 1'b0;
      cyc(6);
      chk("R3 flag cleared after push", pin_ack, 1);
      chk("R3 single word pushed", rx_exp.size(), 0);
      chk("R5 overrun sticky", ovr_flag, 1);

      // R5: second strobe detected in the same cycle as the push
      do_reset();
      chk("R1 overrun cleared by reset", ovr_flag, 0);
      rx_full = 1'b1;
      strobe(8'h11, 1);
      pin_din = 8'h22;
      cyc(1);
      pin_req = 1'b0;
      cyc(2);
      rx_full = 1'b0;
      cyc(1);
      chk("R5 same-cycle overrun", ovr_flag, 1);
      pin_req = 1'b1;
      cyc(1);
      chk("R4 release one edge after push", pin_ack, 1);
      cyc(4);
      chk("R5 same-cycle word dropped", rx_exp.size(), 0);

      // transmit direction
      do_reset();
      cfg_out_dir = 1'b1;
      cfg_delay = 4'd2;
      cyc(3);
      chk("R8 doe transmit", pin_doe, 1);
      tx_word(8'h5A);
      cyc(4);
      chk("R6 flag not yet", pin_ack, 1);
      chk("R6 data ahead of flag", pin_dout, 8'h5A);
      cyc(1);
      chk("R6 flag asserted", pin_ack, 0);
      cyc(3);
      chk("R8 dout held", pin_dout, 8'h5A);
      pin_req = 1'b0;
      cyc(2);
      chk("R7 flag not early", pin_ack, 0);
      cyc(1);
      chk("R7 flag cleared", pin_ack, 1);
      pin_req = 1'b1;
      cyc(2);

      // R7: back-to-back words, peripheral acknowledges each
      tx_word(8'h01);
      tx_word(8'h80);
      tx_word(8'hE7);
      for (int w = 0; w < 3; w++) begin
         int t = 0;
         while (pin_ack !== 1'b0 && t < 50) begin cyc(1); t++; end
         chk("R7 next word flagged", pin_ack, 0);
         cyc(2);
         pin_req = 1'b0;
         cyc(3);
         pin_req = 1'b1;
      end
      cyc(4);
      chk("R7 all words seen", tx_exp.size(), 0);
      chk("R7 queue drained", tx_fifo.size(), 0);

      // R9: acknowledge edge with the flag clear
      pin_req = 1'b0;
      cyc(3);
      pin_req = 1'b1;
      cyc(4);
      chk("R9 flag stays clear", pin_ack, 1);
      chk("R9 dout kept", pin_dout, 8'hE7);
      chk("R9 no overrun", ovr_flag, 0);

      cfg_out_dir = 1'b0;
      cyc(3);
      chk("R8 doe back to receive", pin_doe, 0);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < 20000; i++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule